// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block connects the digital signals of a fixed set of on-chip peripherals to a small bank of physical port pins. It does not use a static per-pin function select. Pins are handed out on the fly. Every enabled peripheral signal, taken in a fixed priority order, receives the next pin that is free, not skipped by software, and not hard-reserved. Any pin that no peripheral claims stays general-purpose I/O, driven from its port latch.

The pin assignment is recomputed every cycle from the enable, skip and global-enable inputs and held in a register. The output data path is combinational through that registered map:

- Each pin drives either its owning peripheral's output value and output-enable, or its GPIO latch value and output-enable.
- Each peripheral input is fed from the pin it owns, or held at an idle level of 1 when it owns no pin.

If the eligible pins run out, the remaining lower-priority signals get no pin and an overflow flag is raised.

Top module: `priority_xbar`

## Requirements
- R1: Signal slots are numbered in priority order, highest priority first. Slots 0-1 are UART transmit then receive. Slots 2-5 are SPI0 and slots 6-9 are SPI1, each as clock, data-in, data-out, select. Slots 10-11 are SMBus data then clock. Slot 12 is comparator 0 and slot 13 is comparator 1. Slot 14 is the clock output. Slots 15-20 are PCA channels 0-5. Slot 21 is timer 0 input and slot 22 is timer 1 input. The unit_en bits are 0 UART, 1 SPI0, 2 SPI1, 3 SMBus, 4 comparator 0, 5 comparator 1, 6 clock output, 7 timer 0, 8 timer 1. The k-th requested slot, counted in slot order, owns the k-th eligible pin, counted from pin 0 upward.
- R2: A pin whose skip_mask bit is 1 is never owned. The signal that would have taken it moves to the next eligible pin.
- R3: Pins 8 to 11 are reserved for the radio link and are never owned by a crossbar signal.
- R4: Pin 15 lies outside the crossbar and is never owned. Only pins 0 to 14 take part in assignment.
- R5: When more slots are requested than there are eligible pins, the lowest-priority requests are left without a pin and alloc_overflow is 1. Otherwise alloc_overflow is 0.
- R6: When xbar_en is 0, no pin is owned, no slot has a pin and alloc_overflow is 0.
- R7: For an owned pin, pin_out and pin_oe equal sig_out and sig_oe of the owning slot. For any other pin, they equal gpio_out and gpio_oe of that pin. This path has no register.
- R8: sig_in of a slot equals pin_in of its assigned pin. A slot with no pin reads 1.
- R9: pca_chans requests PCA channels 0 to pca_chans-1. A value of 0 requests none, and a value of 7 acts as 6.
- R10: The pin map and alloc_overflow reflect the configuration sampled at the previous rising clock edge. While rst_n is low, no pin is owned and alloc_overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the assignment register |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| unit_en | input | 9 | Per-peripheral enables (bit order in R1) |
| pca_chans | input | 3 | Number of PCA channels requested |
| skip_mask | input | 15 | Per-pin skip bits for pins 0 to 14 |
| gpio_out | input | 16 | Port latch value per pin |
| gpio_oe | input | 16 | GPIO output-enable per pin |
| sig_out | input | 23 | Peripheral output value per slot |
| sig_oe | input | 23 | Peripheral output-enable per slot |
| pin_in | input | 16 | Value read at each pin |
| pin_out | output | 16 | Value driven to each pin |
| pin_oe | output | 16 | Output-enable to each pin |
| pin_owned | output | 16 | 1 when the pin belongs to a peripheral slot |
| sig_in | output | 23 | Pin value routed back to each slot |
| alloc_overflow | output | 1 | Requests exceeded the eligible pins |

## Verification
The clocked properties compare the registered map against the skip mask, global enable and eligibility seen one edge earlier. They therefore assume that configuration inputs are stable around each rising edge and are released only after reset. The bench changes configuration only at falling edges and leaves it unchanged for at least one full cycle before sampling. Peripheral and GPIO data are randomised freely, because those paths carry no state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NPIN    = 16;
  localparam int NXB     = 15;
  localparam int NSIG    = 23;
  localparam int NUNIT   = 9;
  localparam int PCA_MAX = 6;
  localparam int SLOT_W  = $clog2(NSIG);
  localparam int PIN_W   = $clog2(NPIN);
  localparam int CNT_W   = $clog2(NSIG + 1);

  localparam int S_UART  = 0;
  localparam int S_SPI0  = 2;
  localparam int S_SPI1  = 6;
  localparam int S_SMB   = 10;
  localparam int S_CMP0  = 12;
  localparam int S_CMP1  = 13;
  localparam int S_CLKO  = 14;
  localparam int S_PCA   = 15;
  localparam int S_TMR0  = 21;
  localparam int S_TMR1  = 22;

  // Clip the requested PCA channel count to the available channels.
  function automatic logic [CNT_W-1:0] pca_span(logic [2:0] n);
    if (int'(n) > PCA_MAX) return CNT_W'(PCA_MAX);
    return CNT_W'(n);
  endfunction

  // Advance a running rank counter by one bit.
  function automatic logic [CNT_W-1:0] rank_step(logic [CNT_W-1:0] r, logic b);
    return r + CNT_W'(b);
  endfunction
endpackage

// File: rtl/xbar_req.sv
module xbar_req
  import xbar_pkg::*;
(
  input  logic             xbar_en,
  input  logic [NUNIT-1:0] unit_en,
  input  logic [2:0]       pca_chans,
  output logic [NSIG-1:0]  req
);
  logic [CNT_W-1:0] pca_n;
  assign pca_n = pca_span(pca_chans);

  always_comb begin
    req = '0;
    if (xbar_en) begin
      for (int i = 0; i < 2; i++) req[S_UART + i] = unit_en[0];
      for (int i = 0; i < 4; i++) req[S_SPI0 + i] = unit_en[1];
      for (int i = 0; i < 4; i++) req[S_SPI1 + i] = unit_en[2];
      for (int i = 0; i < 2; i++) req[S_SMB + i]  = unit_en[3];
      req[S_CMP0] = unit_en[4];
      req[S_CMP1] = unit_en[5];
      req[S_CLKO] = unit_en[6];
      for (int c = 0; c < PCA_MAX; c++) req[S_PCA + c] = (CNT_W'(c) < pca_n);
      req[S_TMR0] = unit_en[7];
      req[S_TMR1] = unit_en[8];
    end
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter logic [NXB-1:0] RSV_MASK = 15'h0F00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSIG-1:0]              req,
  input  logic [NXB-1:0]               skip,
  output logic [NPIN-1:0]              own_q,
  output logic [NPIN-1:0][SLOT_W-1:0]  slot_q,
  output logic [NSIG-1:0]              has_q,
  output logic [NSIG-1:0][PIN_W-1:0]   pin_q,
  output logic                         ovf_q
);
  logic [NPIN-1:0]             elig;
  logic [CNT_W-1:0]            prank [NPIN];
  logic [CNT_W-1:0]            srank [NSIG];
  logic [CNT_W-1:0]            tot_elig, tot_req;
  logic [NPIN-1:0]             own_d;
  logic [NPIN-1:0][SLOT_W-1:0] slot_d;
  logic [NSIG-1:0]             has_d;
  logic [NSIG-1:0][PIN_W-1:0]  pin_d;
  logic                        ovf_d;

  for (genvar p = 0; p < NPIN; p++) begin : g_elig
    if (p < NXB) begin : g_xb
      assign elig[p] = !skip[p] && !RSV_MASK[p];
    end else begin : g_gpio
      assign elig[p] = 1'b0;
    end
  end

  always_comb begin
    logic [CNT_W-1:0] c;
    c = '0;
    for (int p = 0; p < NPIN; p++) begin
      prank[p] = c;
      c = rank_step(c, elig[p]);
    end
    tot_elig = c;
  end

  always_comb begin
    logic [CNT_W-1:0] c;
    c = '0;
    for (int s = 0; s < NSIG; s++) begin
      srank[s] = c;
      c = rank_step(c, req[s]);
    end
    tot_req = c;
  end

  always_comb begin
    own_d  = '0;
    slot_d = '0;
    has_d  = '0;
    pin_d  = '0;
    for (int p = 0; p < NPIN; p++) begin
      for (int s = 0; s < NSIG; s++) begin
        if (elig[p] && req[s] && prank[p] == srank[s]) begin
          own_d[p]  = 1'b1;
          slot_d[p] = SLOT_W'(s);
          has_d[s]  = 1'b1;
          pin_d[s]  = PIN_W'(p);
        end
      end
    end
    ovf_d = tot_req > tot_elig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      slot_q <= '0;
      has_q  <= '0;
      pin_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      own_q  <= own_d;
      slot_q <= slot_d;
      has_q  <= has_d;
      pin_q  <= pin_d;
      ovf_q  <= ovf_d;
    end
  end

  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q[NXB-1:0] & RSV_MASK) == '0);
  a_r4_outside_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !own_q[NPIN-1]);
  a_r2_skip_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q[NXB-1:0] & $past(skip)) == '0);
  a_r5_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $countones(own_q) == $countones($past(elig)));
  a_r1_map_balance: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own_q) == $countones(has_q));
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
(
  input  logic [NPIN-1:0]              own,
  input  logic [NPIN-1:0][SLOT_W-1:0]  slot,
  input  logic [NSIG-1:0]              has,
  input  logic [NSIG-1:0][PIN_W-1:0]   pin,
  input  logic [NSIG-1:0]              sig_out,
  input  logic [NSIG-1:0]              sig_oe,
  input  logic [NPIN-1:0]              gpio_out,
  input  logic [NPIN-1:0]              gpio_oe,
  input  logic [NPIN-1:0]              pin_in,
  output logic [NPIN-1:0]              pin_out,
  output logic [NPIN-1:0]              pin_oe,
  output logic [NSIG-1:0]              sig_in
);
  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      if (own[p]) begin
        pin_out[p] = sig_out[slot[p]];
        pin_oe[p]  = sig_oe[slot[p]];
      end else begin
        pin_out[p] = gpio_out[p];
        pin_oe[p]  = gpio_oe[p];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSIG; s++) begin
      sig_in[s] = has[s] ? pin_in[pin[s]] : 1'b1;
    end
  end
endmodule

// File: rtl/priority_xbar.sv
module priority_xbar
  import xbar_pkg::*;
#(
  parameter logic [NXB-1:0] RSV_MASK = 15'h0F00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xbar_en,
  input  logic [NUNIT-1:0] unit_en,
  input  logic [2:0]       pca_chans,
  input  logic [NXB-1:0]   skip_mask,
  input  logic [NPIN-1:0]  gpio_out,
  input  logic [NPIN-1:0]  gpio_oe,
  input  logic [NSIG-1:0]  sig_out,
  input  logic [NSIG-1:0]  sig_oe,
  input  logic [NPIN-1:0]  pin_in,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NPIN-1:0]  pin_owned,
  output logic [NSIG-1:0]  sig_in,
  output logic             alloc_overflow
);
  logic [NSIG-1:0]             req;
  logic [NPIN-1:0]             own_q;
  logic [NPIN-1:0][SLOT_W-1:0] slot_q;
  logic [NSIG-1:0]             has_q;
  logic [NSIG-1:0][PIN_W-1:0]  pin_q;
  logic                        ovf_q;

  xbar_req u_req (
    .xbar_en   (xbar_en),
    .unit_en   (unit_en),
    .pca_chans (pca_chans),
    .req       (req)
  );

  xbar_alloc #(.RSV_MASK(RSV_MASK)) u_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .skip   (skip_mask),
    .own_q  (own_q),
    .slot_q (slot_q),
    .has_q  (has_q),
    .pin_q  (pin_q),
    .ovf_q  (ovf_q)
  );

  xbar_route u_route (
    .own      (own_q),
    .slot     (slot_q),
    .has      (has_q),
    .pin      (pin_q),
    .sig_out  (sig_out),
    .sig_oe   (sig_oe),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .sig_in   (sig_in)
  );

  assign pin_owned      = own_q;
  assign alloc_overflow = ovf_q;

  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xbar_en) |-> (pin_owned == '0 && !alloc_overflow));
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_owned == '0) |-> (sig_in == '1));
endmodule

// File: tb/tb_priority_xbar.sv
module tb_priority_xbar;
  import xbar_pkg::*;

  logic clk = 0, rst_n = 0, xbar_en = 0;
  logic [NUNIT-1:0] unit_en = '0;
  logic [2:0] pca_chans = '0;
  logic [NXB-1:0] skip_mask = '0;
  logic [NPIN-1:0] gpio_out = '0, gpio_oe = '0, pin_in = '0;
  logic [NSIG-1:0] sig_out = '0, sig_oe = '0;
  logic [NPIN-1:0] pin_out, pin_oe, pin_owned;
  logic [NSIG-1:0] sig_in;
  logic alloc_overflow;

  int checks = 0, errors = 0;
  bit done = 0;

  priority_xbar dut (.*);

  always #5 clk = ~clk;

  // Expected map, built by a serial greedy walk.
  bit e_own [NPIN]; int e_slot [NPIN];
  bit e_has [NSIG]; int e_pin [NSIG];
  bit e_ovf;

  function automatic bit wants(int s);
    int n;
    if (!xbar_en) return 0;
    n = (pca_chans > 6) ? 6 : int'(pca_chans);
    if (s < 2)  return unit_en[0];
    if (s < 6)  return unit_en[1];
    if (s < 10) return unit_en[2];
    if (s < 12) return unit_en[3];
    if (s == 12) return unit_en[4];
    if (s == 13) return unit_en[5];
    if (s == 14) return unit_en[6];
    if (s < 21) return (s - 15) < n;
    if (s == 21) return unit_en[7];
    return unit_en[8];
  endfunction

  function automatic void build_model();
    int ptr = 0;
    e_ovf = 0;
    for (int p = 0; p < NPIN; p++) begin e_own[p] = 0; e_slot[p] = 0; end
    for (int s = 0; s < NSIG; s++) begin e_has[s] = 0; e_pin[s] = 0; end
    for (int s = 0; s < NSIG; s++) begin
      if (wants(s)) begin
        while (ptr < 15 && (skip_mask[ptr] || (ptr >= 8 && ptr <= 11))) ptr++;
        if (ptr < 15) begin
          e_own[ptr] = 1; e_slot[ptr] = s; e_has[s] = 1; e_pin[s] = ptr; ptr++;
        end else e_ovf = 1;
      end
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [NPIN-1:0] eo, ev, ee;
    logic [NSIG-1:0] ei;
    for (int p = 0; p < NPIN; p++) begin
      eo[p] = e_own[p];
      ev[p] = e_own[p] ? sig_out[e_slot[p]] : gpio_out[p];
      ee[p] = e_own[p] ? sig_oe[e_slot[p]]  : gpio_oe[p];
    end
    for (int s = 0; s < NSIG; s++) ei[s] = e_has[s] ? pin_in[e_pin[s]] : 1'b1;
    check({tag, " owned"}, 32'(pin_owned), 32'(eo));
    check("R5 overflow", 32'(alloc_overflow), 32'(e_ovf));
    check("R7 pin_out", 32'(pin_out), 32'(ev));
    check("R7 pin_oe", 32'(pin_oe), 32'(ee));
    check("R8 sig_in", 32'(sig_in), 32'(ei));
    check("R4 pin15", 32'(pin_owned[15]), 32'(0));
    check("R3 reserved", 32'(pin_owned[11:8]), 32'(0));
  endtask

  task automatic rand_data();
    gpio_out = NPIN'($urandom); gpio_oe = NPIN'($urandom);
    pin_in   = NPIN'($urandom);
    sig_out  = NSIG'($urandom); sig_oe = NSIG'($urandom);
  endtask

  task automatic apply(string tag, logic en, logic [NUNIT-1:0] u,
                       logic [2:0] pc, logic [NXB-1:0] sk);
    @(negedge clk);
    xbar_en = en; unit_en = u; pca_chans = pc; skip_mask = sk;
    rand_data();
    @(posedge clk);
    @(negedge clk);
    build_model();
    check_all(tag);
    rand_data();   // data path is combinational: recheck with fresh data
    #1;
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    xbar_en = 1; unit_en = '1; pca_chans = 3'd6;
    repeat (3) @(negedge clk);
    check("R10 reset owned", 32'(pin_owned), 32'(0));
    check("R10 reset overflow", 32'(alloc_overflow), 32'(0));
    check("R10 reset sig_in", 32'(sig_in), 32'h7FFFFF);
    rst_n = 1;

    apply("R1 uart only", 1, 9'h001, 3'd0, '0);
    check("R1 uart pins", 32'(pin_owned), 32'h0003);
    apply("R5 all on", 1, 9'h1FF, 3'd6, '0);
    check("R5 flag set", 32'(alloc_overflow), 32'd1);
    apply("R2 skip", 1, 9'h009, 3'd0, 15'h0005);
    check("R2 skip pins", 32'(pin_owned), 32'h003A);
    apply("R6 disabled", 0, 9'h1FF, 3'd6, '0);
    check("R6 none owned", 32'(pin_owned), 32'd0);
    apply("R9 pca7", 1, 9'h000, 3'd7, '0);
    check("R9 pca clip", 32'(pin_owned), 32'h003F);
    apply("R9 pca3", 1, 9'h000, 3'd3, '0);
    check("R9 pca three", 32'(pin_owned), 32'h0007);
    apply("R3 high pins", 1, 9'h104, 3'd0, 15'h00FF);
    check("R3 only upper", 32'(pin_owned), 32'h7000);

    // R10 latency: map holds until the next rising edge
    @(negedge clk);
    unit_en = 9'h001; pca_chans = 0; skip_mask = '0;
    #1;
    check("R10 map held", 32'(pin_owned), 32'h7000);
    @(posedge clk); @(negedge clk);
    check("R10 map updated", 32'(pin_owned), 32'h0003);

    for (int t = 0; t < 300; t++)
      apply("R1 random", ($urandom % 8) != 0, NUNIT'($urandom),
            3'($urandom), NXB'($urandom & $urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule